// File: doc/BRIEF.md
# Interleaved Closed-Page Request Scheduler

This block sits on the controller side of a packetized DRAM channel. It takes read or write transactions, each aimed at one bank, and runs every one of them with a closed-page policy: one activate, two column accesses, then one precharge. All of these packets go out on one shared request bus. Each packet kind has its own fixed slot phase, so overlapping transactions never ask for the same request slot. For each transaction the block also marks the two data-bus slots that carry its data packets.

A global slot counter opens an activate slot once every `ACT_GAP` cycles. A transaction is accepted only in the cycle just before such a slot. Its activate then appears in the slot itself, and every later packet follows at a fixed offset from that activate. A per-bank timer holds back a new transaction to a bank until that bank's effective cycle time has run out, which covers its precharge. Reads and writes are never in flight together. A new transaction in the other direction waits until every tracked transaction, data included, has finished.

Top module: `rs_req_sched`

## Requirements
- R1: The slot phase restarts at 0 in the first cycle after reset and activate slots recur every 4 cycles. `txn_ready` can be high only in the cycle just before an activate slot. An accepted transaction (`txn_valid && txn_ready` at a clock edge) produces an activate packet (`req_type` 2'b00) with its bank in the next cycle, called A below.
- R2: A write transaction issues column-write packets (`req_type` 2'b10) with its bank in cycles A+1 and A+3.
- R3: A read transaction issues column-read packets (`req_type` 2'b01) with its bank in cycles A+5 and A+7.
- R4: A write transaction marks `dq_valid` with `dq_write`=1 and its bank in cycles A+7 and A+9.
- R5: A read transaction marks `dq_valid` with `dq_write`=0 and its bank in cycles A+11 and A+13.
- R6: A precharge packet (`req_type` 2'b11) with the transaction's bank is issued in cycle A+14 for a write and in cycle A+10 for a read.
- R7: A bank activated for a write cannot be activated again before A+20. A bank activated for a read cannot be activated again before A+16. When nothing else blocks it, the next activate to that bank lands exactly at that cycle.
- R8: At most one request packet is issued per cycle, and `req_valid` is low in every cycle without a scheduled packet. Transactions to distinct free banks in the same direction keep the 4-cycle activate spacing.
- R9: A transaction in the other direction is not accepted while any transaction is in flight. With the default offsets its activate lands 16 cycles after the last activate in the old direction.
- R10: While reset is asserted, `req_valid`, `dq_valid` and `txn_ready` are low, even with `txn_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txn_valid | input | 1 | Transaction offered |
| txn_ready | output | 1 | Transaction accepted at this edge if valid |
| txn_write | input | 1 | 1 = write, 0 = read |
| txn_bank | input | $clog2(NBANK) | Target bank |
| req_valid | output | 1 | A request packet is issued this cycle |
| req_type | output | 2 | 00 activate, 01 column read, 10 column write, 11 precharge |
| req_bank | output | $clog2(NBANK) | Bank of the issued packet |
| dq_valid | output | 1 | Data bus slot carries a data packet this cycle |
| dq_write | output | 1 | Direction of that data packet |
| dq_bank | output | $clog2(NBANK) | Bank of that data packet |

## Verification
Every packet and data slot is due a fixed number of cycles after the activate, and the activate comes one cycle after the accepting edge. The bench notes the cycle of each handshake and writes the whole expected schedule into per-cycle expectation arrays at fixed offsets: column at +1/+3 or +5/+7, data at +7/+9 or +11/+13, precharge at +14 or +10. It then compares both buses against those arrays on every falling edge. A vector table fixes the activate-to-activate gap the requirements call for: 4 for free banks, 20 or 16 for a reused bank, and 16 for a change of direction. Directed steps cover the reset state and the first activate slot after reset.

// File: rtl/rs_pkg.sv
package rs_pkg;

  typedef enum logic [1:0] {
    PKT_ACT   = 2'b00,
    PKT_COLRD = 2'b01,
    PKT_COLWR = 2'b10,
    PKT_PRE   = 2'b11
  } pkt_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rs_slot_phase.sv
module rs_slot_phase #(
  parameter int unsigned ACT_GAP = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic act_next_o
);
  localparam int unsigned PH_W = (ACT_GAP > 2) ? $clog2(ACT_GAP) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(ACT_GAP - 1);

  logic [PH_W-1:0] ph_q, ph_d;

  always_comb begin
    if (ph_q == PH_LAST) ph_d = '0;
    else                 ph_d = ph_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  assign act_next_o = (ph_q == PH_LAST);
endmodule

// File: rtl/rs_bank_timer.sv
module rs_bank_timer #(
  parameter int unsigned NBANK  = 8,
  parameter int unsigned BANK_W = 3,
  parameter int unsigned CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [BANK_W-1:0] load_bank_i,
  input  logic [CNT_W-1:0]  load_val_i,
  output logic [NBANK-1:0]  busy_o
);
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             hit;

    assign hit = load_i && (load_bank_i == BANK_W'(b));

    always_comb begin
      cnt_d = cnt_q;
      if (hit)               cnt_d = load_val_i;
      else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
    end

    assign busy_o[b] = (cnt_q != '0);
  end
endmodule

// File: rtl/rs_txn_slot.sv
module rs_txn_slot #(
  parameter int unsigned BANK_W  = 3,
  parameter int unsigned AGE_W   = 4,
  parameter int unsigned WR_COL0 = 1,
  parameter int unsigned RD_COL0 = 5,
  parameter int unsigned COL_GAP = 2,
  parameter int unsigned DQ_LAT  = 6,
  parameter int unsigned WR_PRE  = 14,
  parameter int unsigned RD_PRE  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              write_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic              active_o,
  output logic              write_o,
  output logic [BANK_W-1:0] bank_o,
  output logic              act_o,
  output logic              col_o,
  output logic              dq_o,
  output logic              pre_o
);
  import rs_pkg::*;

  localparam int unsigned WR_LAST_I = max_u(WR_PRE, WR_COL0 + DQ_LAT + COL_GAP);
  localparam int unsigned RD_LAST_I = max_u(RD_PRE, RD_COL0 + DQ_LAT + COL_GAP);

  localparam logic [AGE_W-1:0] WR_C0   = AGE_W'(WR_COL0);
  localparam logic [AGE_W-1:0] WR_C1   = AGE_W'(WR_COL0 + COL_GAP);
  localparam logic [AGE_W-1:0] RD_C0   = AGE_W'(RD_COL0);
  localparam logic [AGE_W-1:0] RD_C1   = AGE_W'(RD_COL0 + COL_GAP);
  localparam logic [AGE_W-1:0] WR_D0   = AGE_W'(WR_COL0 + DQ_LAT);
  localparam logic [AGE_W-1:0] WR_D1   = AGE_W'(WR_COL0 + DQ_LAT + COL_GAP);
  localparam logic [AGE_W-1:0] RD_D0   = AGE_W'(RD_COL0 + DQ_LAT);
  localparam logic [AGE_W-1:0] RD_D1   = AGE_W'(RD_COL0 + DQ_LAT + COL_GAP);
  localparam logic [AGE_W-1:0] WR_P    = AGE_W'(WR_PRE);
  localparam logic [AGE_W-1:0] RD_P    = AGE_W'(RD_PRE);
  localparam logic [AGE_W-1:0] WR_LAST = AGE_W'(WR_LAST_I);
  localparam logic [AGE_W-1:0] RD_LAST = AGE_W'(RD_LAST_I);

  logic              active_q, active_d;
  logic              write_q, write_d;
  logic [BANK_W-1:0] bank_q, bank_d;
  logic [AGE_W-1:0]  age_q, age_d;
  logic [AGE_W-1:0]  last_age;

  assign last_age = write_q ? WR_LAST : RD_LAST;

  always_comb begin
    active_d = active_q;
    write_d  = write_q;
    bank_d   = bank_q;
    age_d    = age_q;
    if (load_i) begin
      active_d = 1'b1;
      write_d  = write_i;
      bank_d   = bank_i;
      age_d    = '0;
    end else if (active_q) begin
      if (age_q == last_age) active_d = 1'b0;
      else                   age_d    = age_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      write_q  <= 1'b0;
      bank_q   <= '0;
      age_q    <= '0;
    end else begin
      active_q <= active_d;
      write_q  <= write_d;
      bank_q   <= bank_d;
      age_q    <= age_d;
    end
  end

  assign active_o = active_q;
  assign write_o  = write_q;
  assign bank_o   = bank_q;
  assign act_o    = active_q && (age_q == '0);
  assign col_o    = active_q && (write_q ? (age_q == WR_C0 || age_q == WR_C1)
                                         : (age_q == RD_C0 || age_q == RD_C1));
  assign dq_o     = active_q && (write_q ? (age_q == WR_D0 || age_q == WR_D1)
                                         : (age_q == RD_D0 || age_q == RD_D1));
  assign pre_o    = active_q && (age_q == (write_q ? WR_P : RD_P));
endmodule

// File: rtl/rs_req_sched.sv
module rs_req_sched #(
  parameter int unsigned NBANK   = 8,
  parameter int unsigned NSLOT   = 4,
  parameter int unsigned ACT_GAP = 4,
  parameter int unsigned COL_GAP = 2,
  parameter int unsigned WR_COL0 = 1,
  parameter int unsigned RD_COL0 = 5,
  parameter int unsigned DQ_LAT  = 6,
  parameter int unsigned WR_PRE  = 14,
  parameter int unsigned RD_PRE  = 10,
  parameter int unsigned WR_TRC  = 20,
  parameter int unsigned RD_TRC  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     txn_valid,
  output logic                     txn_ready,
  input  logic                     txn_write,
  input  logic [$clog2(NBANK)-1:0] txn_bank,
  output logic                     req_valid,
  output logic [1:0]               req_type,
  output logic [$clog2(NBANK)-1:0] req_bank,
  output logic                     dq_valid,
  output logic                     dq_write,
  output logic [$clog2(NBANK)-1:0] dq_bank
);
  import rs_pkg::*;

  localparam int unsigned BANK_W   = $clog2(NBANK);
  localparam int unsigned SLOT_W   = (NSLOT > 1) ? $clog2(NSLOT) : 1;
  localparam int unsigned CNT_W    = $clog2(max_u(WR_TRC, RD_TRC));
  localparam int unsigned LAST_MAX = max_u(max_u(WR_PRE, RD_PRE),
                                           max_u(WR_COL0, RD_COL0) + DQ_LAT + COL_GAP);
  localparam int unsigned AGE_W    = $clog2(LAST_MAX + 1);

  logic              act_next;
  logic [NBANK-1:0]  bank_busy;
  logic              accept;
  logic              dir_q, dir_d;
  logic              any_active, dir_ok, free_any;
  logic [SLOT_W-1:0] free_idx;
  logic [NSLOT-1:0]  load_vec, active_vec, write_vec;
  logic [NSLOT-1:0]  act_vec, col_vec, dq_vec, pre_vec;
  logic [BANK_W-1:0] slot_bank [NSLOT];

  rs_slot_phase #(.ACT_GAP(ACT_GAP)) u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .act_next_o (act_next)
  );

  rs_bank_timer #(.NBANK(NBANK), .BANK_W(BANK_W), .CNT_W(CNT_W)) u_btimer (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (accept),
    .load_bank_i (txn_bank),
    .load_val_i  (txn_write ? CNT_W'(WR_TRC - 1) : CNT_W'(RD_TRC - 1)),
    .busy_o      (bank_busy)
  );

  // lowest free tracker wins
  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (!active_vec[i]) begin
        free_any = 1'b1;
        free_idx = SLOT_W'(i);
      end
    end
  end

  assign any_active = |active_vec;
  assign dir_ok     = !any_active || (dir_q == txn_write);
  assign txn_ready  = act_next && free_any && dir_ok && !bank_busy[txn_bank];
  assign accept     = txn_valid && txn_ready;

  always_comb begin
    dir_d = dir_q;
    if (accept) dir_d = txn_write;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dir_q <= 1'b0;
    else        dir_q <= dir_d;
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    assign load_vec[s] = accept && (free_idx == SLOT_W'(s));

    rs_txn_slot #(
      .BANK_W (BANK_W), .AGE_W (AGE_W),
      .WR_COL0(WR_COL0), .RD_COL0(RD_COL0), .COL_GAP(COL_GAP),
      .DQ_LAT (DQ_LAT),  .WR_PRE (WR_PRE),  .RD_PRE (RD_PRE)
    ) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (load_vec[s]),
      .write_i  (txn_write),
      .bank_i   (txn_bank),
      .active_o (active_vec[s]),
      .write_o  (write_vec[s]),
      .bank_o   (slot_bank[s]),
      .act_o    (act_vec[s]),
      .col_o    (col_vec[s]),
      .dq_o     (dq_vec[s]),
      .pre_o    (pre_vec[s])
    );
  end

  // merge: the fixed slot phases keep at most one source active per cycle
  always_comb begin
    req_valid = 1'b0;
    req_type  = PKT_ACT;
    req_bank  = '0;
    dq_valid  = 1'b0;
    dq_write  = 1'b0;
    dq_bank   = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (act_vec[i]) begin
        req_valid = 1'b1;
        req_type  = PKT_ACT;
        req_bank  = slot_bank[i];
      end
      if (col_vec[i]) begin
        req_valid = 1'b1;
        req_type  = write_vec[i] ? PKT_COLWR : PKT_COLRD;
        req_bank  = slot_bank[i];
      end
      if (pre_vec[i]) begin
        req_valid = 1'b1;
        req_type  = PKT_PRE;
        req_bank  = slot_bank[i];
      end
      if (dq_vec[i]) begin
        dq_valid = 1'b1;
        dq_write = write_vec[i];
        dq_bank  = slot_bank[i];
      end
    end
  end
endmodule

// File: rtl/rs_req_sched_chk.sv
module rs_req_sched_chk #(
  parameter int unsigned NSLOT  = 4,
  parameter int unsigned BANK_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              txn_valid,
  input logic              txn_ready,
  input logic              txn_write,
  input logic [BANK_W-1:0] txn_bank,
  input logic              req_valid,
  input logic [1:0]        req_type,
  input logic [BANK_W-1:0] req_bank,
  input logic [NSLOT-1:0]  act_vec,
  input logic [NSLOT-1:0]  col_vec,
  input logic [NSLOT-1:0]  pre_vec
);
  logic hs, act_out;
  assign hs      = txn_valid && txn_ready;
  assign act_out = req_valid && (req_type == 2'b00);

  assert_act_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hs |=> (act_out && req_bank == $past(txn_bank)));

  assert_act_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    act_out |-> !($past(act_out, 1) || $past(act_out, 2) || $past(act_out, 3)));

  assert_wr_col_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hs && txn_write, 2) |-> (req_valid && req_type == 2'b10));

  assert_rd_pre_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hs && !txn_write, 11) |-> (req_valid && req_type == 2'b11));

  assert_one_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({act_vec, col_vec, pre_vec}));
endmodule

bind rs_req_sched rs_req_sched_chk #(.NSLOT(NSLOT), .BANK_W(BANK_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .txn_valid (txn_valid),
  .txn_ready (txn_ready),
  .txn_write (txn_write),
  .txn_bank  (txn_bank),
  .req_valid (req_valid),
  .req_type  (req_type),
  .req_bank  (req_bank),
  .act_vec   (act_vec),
  .col_vec   (col_vec),
  .pre_vec   (pre_vec)
);

// File: tb/rs_req_sched_tb.sv
module rs_req_sched_tb;
  localparam int NV   = 16;
  localparam int DEPTH = 4096;
  localparam int WD   = 20000;

  // vector: {write, bank[2:0], expected activate gap[4:0]}, gap 0 = not checked
  localparam logic [8:0] VEC [0:NV-1] = '{
    {1'b1, 3'd0, 5'd0},  {1'b1, 3'd1, 5'd4},  {1'b1, 3'd2, 5'd4},  {1'b1, 3'd3, 5'd4},
    {1'b1, 3'd4, 5'd4},  {1'b1, 3'd0, 5'd4},  {1'b1, 3'd0, 5'd20}, {1'b0, 3'd1, 5'd16},
    {1'b0, 3'd2, 5'd4},  {1'b0, 3'd3, 5'd4},  {1'b0, 3'd4, 5'd4},  {1'b0, 3'd1, 5'd4},
    {1'b0, 3'd1, 5'd16}, {1'b1, 3'd5, 5'd16}, {1'b1, 3'd6, 5'd4},  {1'b0, 3'd7, 5'd16}
  };

  logic       clk, rst_n;
  logic       txn_valid, txn_ready, txn_write;
  logic [2:0] txn_bank;
  logic       req_valid;
  logic [1:0] req_type;
  logic [2:0] req_bank;
  logic       dq_valid, dq_write;
  logic [2:0] dq_bank;

  int n_chk, n_bad, cyc;
  bit run_mon;
  bit       e_rv [DEPTH];
  bit [1:0] e_rt [DEPTH];
  bit [2:0] e_rb [DEPTH];
  bit       e_dv [DEPTH];
  bit       e_dw [DEPTH];
  bit [2:0] e_db [DEPTH];

  rs_req_sched u_dut (
    .clk(clk), .rst_n(rst_n), .txn_valid(txn_valid), .txn_ready(txn_ready),
    .txn_write(txn_write), .txn_bank(txn_bank), .req_valid(req_valid),
    .req_type(req_type), .req_bank(req_bank), .dq_valid(dq_valid),
    .dq_write(dq_write), .dq_bank(dq_bank)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, WD);
      report();
    end
  end

  task automatic put_req(input int c, input bit [1:0] t, input bit [2:0] b);
    if (e_rv[c]) check(1'b0, "R8 slot clash in expectation", c, 0);
    e_rv[c] = 1'b1; e_rt[c] = t; e_rb[c] = b;
  endtask

  task automatic put_dq(input int c, input bit w, input bit [2:0] b);
    e_dv[c] = 1'b1; e_dw[c] = w; e_db[c] = b;
  endtask

  task automatic plan(input int a, input bit w, input bit [2:0] b);
    put_req(a, 2'b00, b);                        // R1
    if (w) begin
      put_req(a + 1, 2'b10, b); put_req(a + 3, 2'b10, b);   // R2
      put_dq(a + 7, 1'b1, b);   put_dq(a + 9, 1'b1, b);     // R4
      put_req(a + 14, 2'b11, b);                            // R6
    end else begin
      put_req(a + 5, 2'b01, b); put_req(a + 7, 2'b01, b);   // R3
      put_dq(a + 11, 1'b0, b);  put_dq(a + 13, 1'b0, b);    // R5
      put_req(a + 10, 2'b11, b);                            // R6
    end
  endtask

  function automatic string req_tag(input bit v, input bit [1:0] t);
    if (!v) return "R8 idle";
    case (t)
      2'b00:   return "R1 activate";
      2'b10:   return "R2 column write";
      2'b01:   return "R3 column read";
      default: return "R6 precharge";
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n && run_mon) begin
      if (req_valid || e_rv[cyc]) begin
        check(req_valid === e_rv[cyc] &&
              (!e_rv[cyc] || (req_type === e_rt[cyc] && req_bank === e_rb[cyc])),
              req_tag(e_rv[cyc], e_rt[cyc]),
              {req_valid, req_type, req_bank}, {e_rv[cyc], e_rt[cyc], e_rb[cyc]});
      end
      if (dq_valid || e_dv[cyc]) begin
        check(dq_valid === e_dv[cyc] &&
              (!e_dv[cyc] || (dq_write === e_dw[cyc] && dq_bank === e_db[cyc])),
              e_dw[cyc] ? "R4 write data slot" : "R5 read data slot",
              {dq_valid, dq_write, dq_bank}, {e_dv[cyc], e_dw[cyc], e_db[cyc]});
      end
    end
  end

  // offer one transaction, return the cycle of its activate
  task automatic send(input bit w, input bit [2:0] b, output int act_cyc);
    txn_valid = 1'b1; txn_write = w; txn_bank = b;
    #1;
    while (!txn_ready) begin
      @(negedge clk); #1;
    end
    act_cyc = cyc + 1;
    plan(act_cyc, w, b);
    @(negedge clk);
    txn_valid = 1'b0;
  endtask

  initial begin
    int prev_act, a, rel;
    n_chk = 0; n_bad = 0; cyc = 0; run_mon = 1'b0;
    rst_n = 1'b0; txn_valid = 1'b0; txn_write = 1'b0; txn_bank = '0;
    for (int i = 0; i < DEPTH; i++) begin
      e_rv[i] = 1'b0; e_dv[i] = 1'b0; e_rt[i] = '0; e_rb[i] = '0; e_dw[i] = 1'b0; e_db[i] = '0;
    end
    repeat (3) @(negedge clk);
    // R10: reset holds everything low even with a request offered
    txn_valid = 1'b1; txn_write = 1'b1; txn_bank = 3'd2;
    #1;
    check(!req_valid && !dq_valid && !txn_ready, "R10 reset state",
          {req_valid, dq_valid, txn_ready}, 0);
    txn_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    run_mon = 1'b1;
    @(negedge clk);

    prev_act = 0;
    for (int v = 0; v < NV; v++) begin
      send(VEC[v][8], VEC[v][7:5], a);
      if (VEC[v][4:0] != 0) begin
        string tag;
        if (VEC[v][4:0] == 5'd4)        tag = "R8 activate spacing";
        else if (VEC[v][8] != VEC[v-1][8]) tag = "R9 direction change gap";
        else                             tag = "R7 bank reuse gap";
        check(a - prev_act == int'(VEC[v][4:0]), tag, a - prev_act, VEC[v][4:0]);
      end
      prev_act = a;
    end

    repeat (30) @(negedge clk);

    // R10 then R1: reset with a request held, first activate after release
    rst_n = 1'b0; run_mon = 1'b0;
    txn_valid = 1'b1; txn_write = 1'b1; txn_bank = 3'd3;
    #1;
    check(!req_valid && !dq_valid && !txn_ready, "R10 reset with valid held",
          {req_valid, dq_valid, txn_ready}, 0);
    @(negedge clk);
    rst_n = 1'b1; run_mon = 1'b1;
    rel = cyc;
    send(1'b1, 3'd3, a);
    check(a == rel + 4, "R1 first activate slot after reset", a - rel, 4);
    repeat (24) @(negedge clk);
    report();
  end
endmodule